// File: doc/BRIEF.md
# Two-Space I2C Slave with Paged Write Store

This block is the I2C slave end of a small byte store. It watches SCL and SDA as sampled inputs, finds start and stop conditions, and takes a device byte that chooses one of two address spaces. One space is a 512-byte data array. The other is a 64-byte control space that holds a status register. Two word-address bytes then form a 9-bit pointer. Data bytes that follow are stored at the pointer, which steps forward inside its 64-byte page and wraps back to the start of that page.

A stop that ends a write carrying data starts an internal write interval of a fixed number of clock cycles. During that interval the block ignores the bus and raises `busy`. Control-space locations other than the status register accept data only after two completed status writes, 02h and then 06h. A current-address read returns bytes from the pointer for as long as the master acknowledges them.

SDA is an open-drain line. `sda_oe` high pulls the line low.

Top module: `pgm_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) begins a new device byte. A rising SDA while SCL is high (stop) returns the block to idle. Bytes sent after a stop without a new start get no ACK.
- R2: The device byte 1010_111 plus the R/W bit (LSB, 1 = read) selects the data array. The device byte 1101_111 plus the R/W bit selects the control space. Any other device byte gets no ACK, and the block stays idle until the next start.
- R3: The first word-address byte supplies address bit 8 in its LSB. The second word-address byte supplies bits 7..0. Addresses 1A5h and 0A5h are therefore separate locations.
- R4: An accepted device byte, each word-address byte and each received data byte are answered by `sda_oe` high during the ninth SCL clock only.
- R5: A byte write (device, two address bytes, one data byte, stop) stores the data byte at the addressed location.
- R6: A stop after at least one data byte raises `busy` for exactly WR_CYCLES clock cycles. A stop after only address bytes does not raise `busy`.
- R7: While `busy` is high, `sda_oe` stays low, no byte is acknowledged, and a complete write attempted in that window changes nothing.
- R8: During a multi-byte write, the pointer advances only inside its 64-byte page and wraps from the last byte to the first. Thirty bytes written from address 40 fill 40..63 and then 0..5, which leaves the pointer at 6.
- R9: A device byte with R/W = 1 reads from the pointer, MSB first, with each bit driven while SCL is low. The pointer advances inside its page after each byte the master acknowledges. A master NACK ends the read.
- R10: The status register is control address 03Fh, and a write to it is always stored. Other control locations become writable only after a completed write operation of 02h to the status register, followed directly by one of 06h.
- R11: Any other completed write operation between the two unlock steps cancels the sequence. A status write of any other value relocks the control space. While the control space is locked, writes to it are acknowledged but discarded.
- R12: After reset, `sda_oe` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (ACK or read data 0) |
| busy | output | 1 | High during the internal write interval |

## Verification
The hardest situations to reach from the ports are a full write transaction issued inside the busy window and an unrelated write placed between the two unlock steps. To reach the first, the bench sets WR_CYCLES long enough for a complete four-byte write to run while `busy` is high, then reads the target location back afterwards. To reach the second, the bench chains separate write operations, each ended by a stop and each waiting out its own busy interval. The control-space location is read back after each step, so the state of the unlock sequence is only ever observed through data that was kept or dropped.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  localparam int ADDR_W = 9;
  localparam int PAGE_W = 6;

  typedef logic [ADDR_W-1:0] waddr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WA1, ST_WA0, ST_WDATA, ST_RDATA
  } bus_st_e;

  typedef enum logic [1:0] {
    UL_LOCKED, UL_STEP1, UL_OPEN
  } unl_e;

  localparam logic [3:0] ID_ARRAY    = 4'b1010;
  localparam logic [3:0] ID_CTRL     = 4'b1101;
  localparam logic [2:0] ID_LOW      = 3'b111;
  localparam waddr_t     STATUS_ADDR = waddr_t'(9'h03F);
  localparam logic [7:0] UNLOCK_A    = 8'h02;
  localparam logic [7:0] UNLOCK_B    = 8'h06;

  // Next pointer: upper (page) bits held, low bits wrap.
  function automatic waddr_t page_next(input waddr_t a);
    waddr_t m;
    m = waddr_t'((1 << PAGE_W) - 1);
    return (a & ~m) | ((a + waddr_t'(1)) & m);
  endfunction

  // Returns {hit, is_ctrl} for a device byte (R/W bit ignored).
  function automatic logic [1:0] dev_decode(input logic [7:0] b);
    if (b[7:1] == {ID_ARRAY, ID_LOW}) return 2'b10;
    if (b[7:1] == {ID_CTRL, ID_LOW})  return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/pgm_line_sampler.sv
module pgm_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_s1, scl_s2, scl_d;
  logic sda_s1, sda_s2, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_s1, scl_s2, scl_d} <= 3'b111;
      {sda_s1, sda_s2, sda_d} <= 3'b111;
    end else begin
      scl_s1 <= scl_i;  scl_s2 <= scl_s1;  scl_d <= scl_s2;
      sda_s1 <= sda_i;  sda_s2 <= sda_s1;  sda_d <= sda_s2;
    end
  end

  assign sda_q    = sda_s2;
  assign scl_rise = scl_s2 & ~scl_d;
  assign scl_fall = ~scl_s2 & scl_d;
  assign start_ev = scl_s2 & scl_d & sda_d & ~sda_s2;
  assign stop_ev  = scl_s2 & scl_d & ~sda_d & sda_s2;

endmodule

// File: rtl/pgm_byte_ram.sv
module pgm_byte_ram #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/pgm_unlock.sv
module pgm_unlock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_done,
  input  logic       op_status,
  input  logic [7:0] op_value,
  output logic       open
);
  import pgm_pkg::*;

  unl_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= UL_LOCKED;
    end else if (op_done) begin
      if (op_status) begin
        if (op_value == UNLOCK_A)                           st <= UL_STEP1;
        else if (op_value == UNLOCK_B && st == UL_STEP1)    st <= UL_OPEN;
        else                                                st <= UL_LOCKED;
      end else if (st == UL_STEP1) begin
        st <= UL_LOCKED;
      end
    end
  end

  assign open = (st == UL_OPEN);

  AST_UNLOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> ($past(st) == UL_STEP1)); // R10

endmodule

// File: rtl/pgm_i2c_slave.sv
module pgm_i2c_slave #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  import pgm_pkg::*;

  localparam int CNT_W   = $clog2(WR_CYCLES + 1);
  localparam int CTRL_AW = PAGE_W;

  logic sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  pgm_line_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_st_e          st;
  logic [3:0]       bitcnt;
  logic [6:0]       shreg;
  logic [7:0]       txbyte;
  waddr_t           ptr, op_start;
  logic             op_ctrl, op_rw, op_has_data, ack_pend;
  logic [7:0]       op_first;
  logic [CNT_W-1:0] busy_cnt;

  // Named internal events for the assertions
  logic       rx_state, byte_done, data_we, ctrl_we, op_done, ul_open;
  logic [7:0] byte_val, data_rdata, ctrl_rdata, rd_byte;
  logic [1:0] dev_dec;

  assign rx_state  = (st == ST_DEV) || (st == ST_WA1) || (st == ST_WA0) || (st == ST_WDATA);
  assign byte_val  = {shreg, sda_q};
  assign byte_done = rx_state && scl_rise && (bitcnt == 4'd7);
  assign dev_dec   = dev_decode(byte_val);
  assign data_we   = byte_done && (st == ST_WDATA) && !op_ctrl;
  assign ctrl_we   = byte_done && (st == ST_WDATA) && op_ctrl && ((ptr == STATUS_ADDR) || ul_open);
  assign op_done   = stop_ev && !busy && op_has_data;
  assign rd_byte   = op_ctrl ? ctrl_rdata : data_rdata;
  assign busy      = (busy_cnt != '0);

  pgm_byte_ram #(.AW(ADDR_W)) u_data_ram (
    .clk(clk), .rst_n(rst_n), .we(data_we), .addr(ptr),
    .wdata(byte_val), .rdata(data_rdata)
  );

  pgm_byte_ram #(.AW(CTRL_AW)) u_ctrl_ram (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .addr(ptr[CTRL_AW-1:0]),
    .wdata(byte_val), .rdata(ctrl_rdata)
  );

  pgm_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .op_done(op_done),
    .op_status(op_ctrl && (op_start == STATUS_ADDR)),
    .op_value(op_first), .open(ul_open)
  );

  // Internal write interval
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (busy)     busy_cnt <= busy_cnt - CNT_W'(1);
    else if (op_done)  busy_cnt <= CNT_W'(WR_CYCLES);
  end

  // Bus state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  txbyte <= '0;
      ptr <= '0;  op_start <= '0;  op_first <= '0;
      op_ctrl <= 1'b0;  op_rw <= 1'b0;  op_has_data <= 1'b0;
      ack_pend <= 1'b0;  sda_oe <= 1'b0;
    end else if (busy) begin
      st <= ST_IDLE;  bitcnt <= '0;  sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV;  bitcnt <= '0;  sda_oe <= 1'b0;  op_has_data <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE;  bitcnt <= '0;  sda_oe <= 1'b0;  op_has_data <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= byte_val[6:0];
          bitcnt <= bitcnt + 4'd1;
        end else begin
          bitcnt <= 4'd9;
        end
        if (bitcnt == 4'd7) begin
          ack_pend <= 1'b1;
          case (st)
            ST_DEV: begin
              if (dev_dec[1]) begin
                op_ctrl <= dev_dec[0];
                op_rw   <= byte_val[0];
              end else begin
                st       <= ST_IDLE;
                ack_pend <= 1'b0;
              end
            end
            ST_WA1: ptr[ADDR_W-1]   <= byte_val[0];
            ST_WA0: ptr[7:0]        <= byte_val;
            default: begin
              ptr <= page_next(ptr);
              if (!op_has_data) begin
                op_first <= byte_val;
                op_start <= ptr;
              end
              op_has_data <= 1'b1;
            end
          endcase
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          sda_oe <= ack_pend;
        end else if (bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          case (st)
            ST_DEV: begin
              if (op_rw) begin
                st     <= ST_RDATA;
                txbyte <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                st <= ST_WA1;
              end
            end
            ST_WA1:  st <= ST_WA0;
            ST_WA0:  st <= ST_WDATA;
            default: st <= ST_WDATA;
          endcase
        end
      end
    end else if (st == ST_RDATA) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          if (sda_q) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
          end else begin
            ptr    <= page_next(ptr);
            bitcnt <= 4'd9;
          end
        end else begin
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          sda_oe <= ~txbyte[6];
          txbyte <= txbyte << 1;
        end else if (bitcnt == 4'd8) begin
          sda_oe <= 1'b0;
        end else if (bitcnt == 4'd9) begin
          txbyte <= rd_byte;
          sda_oe <= ~rd_byte[7];
          bitcnt <= '0;
        end
      end
    end
  end

  // Checker-side run length of busy
  logic [CNT_W-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + CNT_W'(1);
    else           busy_run <= '0;
  end

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R7

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == CNT_W'(WR_CYCLES))); // R6

  AST_NO_STORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we || ctrl_we) |-> !busy); // R7

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA && byte_done) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R8

  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state && sda_oe) |-> (bitcnt >= 4'd8)); // R4

endmodule

// File: tb/test_pgm_i2c_slave.sv
module test_pgm_i2c_slave;

  localparam int WR = 2000;
  localparam int Q  = 6;
  localparam logic [7:0] DEV_AW = 8'hAE, DEV_AR = 8'hAF;
  localparam logic [7:0] DEV_CW = 8'hDE, DEV_CR = 8'hDF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, busy;
  logic sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  pgm_i2c_slave #(.WR_CYCLES(WR)) i_pgm_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  int run = 0, last_run = 0;
  bit oe_in_busy = 0;
  logic [7:0] rbuf [8];

  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
    if (busy && sda_oe) oe_in_busy = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1; wq(Q); scl = 1; wq(Q); m_sda = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 0; wq(Q); scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
    end
    m_sda = 1; wq(Q); scl = 1; wq(Q);
    ack = !sda_line;
    wq(Q); scl = 0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1; wq(Q); b[i] = sda_line; wq(Q); scl = 0;
    end
    wq(Q); m_sda = mack ? 1'b0 : 1'b1; wq(Q);
    scl = 1; wq(2*Q); scl = 0; wq(Q); m_sda = 1;
  endtask

  task automatic wait_idle;
    wq(8);
    while (busy) wq(1);
    wq(4);
  endtask

  // Write n bytes (base, base+1, ...) from address a; returns count of missing ACKs
  task automatic wr_op(input logic [7:0] dev, input logic [8:0] a, input int n,
                       input logic [7:0] base, output int nacks);
    bit ack;
    nacks = 0;
    i2c_start;
    send_byte(dev, ack);               if (!ack) nacks++;
    send_byte({7'd0, a[8]}, ack);      if (!ack) nacks++;
    send_byte(a[7:0], ack);            if (!ack) nacks++;
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack);    if (!ack) nacks++;
    end
    i2c_stop;
  endtask

  task automatic set_addr(input logic [7:0] dev, input logic [8:0] a);
    int nk;
    wr_op(dev, a, 0, 8'h00, nk);
  endtask

  task automatic rd_cur(input logic [7:0] devr, input int n);
    bit ack;
    i2c_start;
    send_byte(devr, ack);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    i2c_stop;
  endtask

  task automatic t_reset;
    chk(sda_oe == 0, "R12 sda_oe after reset", int'(sda_oe), 0);
    chk(busy == 0,   "R12 busy after reset",   int'(busy), 0);
  endtask

  task automatic t_byte_write;
    int nk;
    last_run = 0;
    wr_op(DEV_AW, 9'h1A5, 1, 8'h3C, nk);
    chk(nk == 0, "R4 ACKs on byte write (R1 start accepted)", nk, 0);
    wait_idle;
    chk(last_run == WR, "R6 busy length", last_run, WR);
    last_run = 0;
    set_addr(DEV_AW, 9'h1A5);
    wq(20);
    chk(busy == 0 && last_run == 0, "R6 no busy after address-only op", last_run, 0);
    rd_cur(DEV_AR, 1);
    chk(rbuf[0] == 8'h3C, "R5 byte readback", rbuf[0], 8'h3C);
    set_addr(DEV_AW, 9'h0A5);
    rd_cur(DEV_AR, 1);
    chk(rbuf[0] == 8'h00, "R3 A8 separates 0A5h", rbuf[0], 8'h00);
  endtask

  task automatic t_bad_dev;
    bit ack;
    i2c_start; send_byte(8'hB6, ack); i2c_stop;
    chk(!ack, "R2 foreign identifier NACK", int'(ack), 0);
    i2c_start; send_byte(8'hD0, ack);
    chk(!ack, "R2 wrong low bits NACK", int'(ack), 0);
    send_byte(DEV_AW, ack);
    chk(!ack, "R2 idle after rejected byte", int'(ack), 0);
    i2c_stop;
    send_byte(DEV_AW, ack);
    chk(!ack, "R1 no ACK after stop without start", int'(ack), 0);
    i2c_stop;
  endtask

  task automatic t_busy_deaf;
    int nk;
    wr_op(DEV_AW, 9'h010, 1, 8'h11, nk);
    oe_in_busy = 0;
    chk(busy == 1, "R6 busy raised after data stop", int'(busy), 1);
    wr_op(DEV_AW, 9'h010, 1, 8'h99, nk);
    chk(busy == 1, "R7 attempt fitted inside busy", int'(busy), 1);
    chk(nk == 4, "R7 no ACK while busy", nk, 4);
    chk(!oe_in_busy, "R7 SDA released while busy", int'(oe_in_busy), 0);
    wait_idle;
    set_addr(DEV_AW, 9'h010);
    rd_cur(DEV_AR, 1);
    chk(rbuf[0] == 8'h11, "R7 write during busy ignored", rbuf[0], 8'h11);
  endtask

  task automatic t_page_wrap;
    int nk;
    wr_op(DEV_AW, 9'd6, 1, 8'h77, nk);
    wait_idle;
    wr_op(DEV_AW, 9'd40, 30, 8'h80, nk);
    chk(nk == 0, "R4 ACK every page byte", nk, 0);
    wait_idle;
    rd_cur(DEV_AR, 1);
    chk(rbuf[0] == 8'h77, "R8 pointer left at 6", rbuf[0], 8'h77);
    set_addr(DEV_AW, 9'd62);
    rd_cur(DEV_AR, 4);
    chk(rbuf[0] == 8'h96, "R8 address 62", rbuf[0], 8'h96);
    chk(rbuf[1] == 8'h97, "R8 address 63", rbuf[1], 8'h97);
    chk(rbuf[2] == 8'h98, "R9 read wraps to 0", rbuf[2], 8'h98);
    chk(rbuf[3] == 8'h99, "R8 address 1", rbuf[3], 8'h99);
    set_addr(DEV_AW, 9'd5);
    rd_cur(DEV_AR, 2);
    chk(rbuf[0] == 8'h9D, "R8 last byte at 5", rbuf[0], 8'h9D);
    chk(rbuf[1] == 8'h77, "R9 sequential read reaches 6", rbuf[1], 8'h77);
    set_addr(DEV_AW, 9'd64);
    rd_cur(DEV_AR, 1);
    chk(rbuf[0] == 8'h00, "R8 next page untouched", rbuf[0], 8'h00);
  endtask

  task automatic t_unlock;
    int nk;
    wr_op(DEV_CW, 9'h010, 1, 8'hAA, nk);
    chk(nk == 0, "R11 locked control write still ACKed", nk, 0);
    wait_idle;
    set_addr(DEV_CW, 9'h010); rd_cur(DEV_CR, 1);
    chk(rbuf[0] == 8'h00, "R11 locked write discarded", rbuf[0], 8'h00);
    wr_op(DEV_CW, 9'h03F, 1, 8'h02, nk); wait_idle;
    wr_op(DEV_AW, 9'h020, 1, 8'h55, nk); wait_idle;
    wr_op(DEV_CW, 9'h03F, 1, 8'h06, nk); wait_idle;
    wr_op(DEV_CW, 9'h010, 1, 8'hAA, nk); wait_idle;
    set_addr(DEV_CW, 9'h010); rd_cur(DEV_CR, 1);
    chk(rbuf[0] == 8'h00, "R11 interleaved write cancels unlock", rbuf[0], 8'h00);
    wr_op(DEV_CW, 9'h03F, 1, 8'h02, nk); wait_idle;
    wr_op(DEV_CW, 9'h03F, 1, 8'h06, nk); wait_idle;
    set_addr(DEV_CW, 9'h03F); rd_cur(DEV_CR, 1);
    chk(rbuf[0] == 8'h06, "R10 status register stored", rbuf[0], 8'h06);
    wr_op(DEV_CW, 9'h010, 1, 8'h5A, nk); wait_idle;
    set_addr(DEV_CW, 9'h010); rd_cur(DEV_CR, 1);
    chk(rbuf[0] == 8'h5A, "R10 control write after unlock", rbuf[0], 8'h5A);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run;
  end

  initial begin
    wq(5);
    t_reset;
    rst_n = 1'b1;
    wq(10);
    t_reset;
    t_byte_write;
    t_bad_dev;
    t_busy_deaf;
    t_page_wrap;
    t_unlock;
    finish_run;
  end

endmodule